// File: doc/BRIEF.md
# USB Receive Status and Bus-Event Monitor

This block sits next to a full-speed USB receive path and keeps one status byte that describes the packet now arriving and the bus events seen since software last looked. Three flags follow the packet in flight: token, data or handshake. The upstream PID decoder sets them, and the end-of-packet strobe clears them. Five sticky flags record bus events: end of packet, USB reset, entry into SE0, resume signalling, and a watchdog error for a packet with no end. Once set, these five stay set until software clears them with a write-one-to-clear mask.

Three control inputs shape the behaviour:
- The reset-detect mode picks how a USB reset is recognised. Mode 0 requires a wide SE0. Mode 1 takes any J-to-SE0 edge at once.
- The interrupt enable gates a one-cycle receive request that fires at the end of a data or handshake packet.
- The write mask limits receive-buffer writes to the low address range. The block passes on write requests as a registered, gated write enable.

Top module: `usb_rx_status_mon`

## Requirements
- R1: A `pid_vld` strobe sets the packet flags from the low PID bits on the next edge. The flags are status[0] token (PID ??01), status[1] data (??11) and status[2] handshake (??10). Only the newest class is kept. A special PID (??00) leaves all three flags at 0.
- R2: An `eop` strobe without `pid_vld` clears status[2:0] and sets status[3] on the next edge. The software clear cannot touch status[2:0].
- R3: Status bits 7..3 are sticky and are cleared only by `sw_clr` with the matching `sw_clr_mask` bit set. A hardware set in the same cycle as a clear wins.
- R4: Line encoding is 00 SE0, 01 J, 10 K, 11 SE1. Entering SE0 from any other state sets status[5] on the next edge.
- R5: With `ctl_rst_mode`=0, status[4] is set on the edge that samples SE0 for the SE0_MIN_CYC-th consecutive cycle. SE0_MIN_CYC is RST_MIN_NS (3000 ns) expressed in clock cycles. A shorter SE0 does not set status[4].
- R6: With `ctl_rst_mode`=1, a J-to-SE0 transition sets status[4] on the next edge. A K-to-SE0 transition does not.
- R7: status[6] (resume) is set when K is held for RSM_BITS bit times. RSM_BITS is 8 bit times, which is 32 cycles by default. A shorter K run leaves status[6] at 0.
- R8: status[7] is set when no EOP arrives within WDT_BITS bit times after a token, data or handshake PID. It is set on the WDT_CYC-th edge after the PID edge, which is 256 cycles by default. An EOP before that point prevents it. Entering SE1 also sets status[7]. Software can clear this bit but cannot set it.
- R9: When `ctl_irq_en`=1 and an EOP ends a data or handshake packet, `rx_irq` is high for exactly the one cycle after that EOP edge. `rx_irq` stays low for token packets, and always stays low when the enable is 0.
- R10: `buf_wr_en` follows `wr_req` one cycle later. When `ctl_wr_mask`=1, requests to addresses above 0x11 are suppressed.
- R11: Reset clears the status byte, `rx_irq` and `buf_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_state | input | 2 | Decoded bus state: 00 SE0, 01 J, 10 K, 11 SE1 |
| pid_vld | input | 1 | Strobe: a PID was detected |
| pid | input | 4 | Detected PID |
| eop | input | 1 | Strobe: end of packet |
| wr_req | input | 1 | Receive-buffer write request |
| wr_addr | input | ADDR_W | Receive-buffer write address |
| sw_clr | input | 1 | Software clear strobe |
| sw_clr_mask | input | 5 | Write-one-to-clear mask for status bits 7..3 |
| ctl_rst_mode | input | 1 | Reset detect: 0 wide SE0, 1 J-to-SE0 edge |
| ctl_irq_en | input | 1 | Receive interrupt enable |
| ctl_wr_mask | input | 1 | Limit buffer writes to addresses up to 0x11 |
| status | output | 8 | Status byte |
| rx_irq | output | 1 | Receive interrupt request pulse |
| buf_wr_en | output | 1 | Gated buffer write enable |

## Verification
Most faults in this block are width and count faults in the two run-length counters or the watchdog counter. Each one shows as a status bit that rises one cycle early, one cycle late, or never. The bench therefore checks each such bit on the exact edge just below and at each limit.

A wrong packet-tracking state shows within one cycle in two ways: as the wrong status[2:0] after a PID or EOP, or as an `rx_irq` pulse on the wrong packet class. A broken clear or set priority shows on the first cycle in which software and hardware hit the same bit.

// File: rtl/usb_rxmon_pkg.sv
package usb_rxmon_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  localparam int ST_TOK = 0;
  localparam int ST_DAT = 1;
  localparam int ST_HSK = 2;
  localparam int ST_EOP = 3;
  localparam int ST_RST = 4;
  localparam int ST_SE0 = 5;
  localparam int ST_RSM = 6;
  localparam int ST_WDT = 7;

  // one-hot packet class from a PID: {handshake, data, token}
  function automatic logic [2:0] pid_class(input logic [3:0] p);
    logic [2:0] c;
    casez (p)
      4'b??01: c = 3'b001;
      4'b??11: c = 3'b010;
      4'b??10: c = 3'b100;
      default: c = 3'b000;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/usb_rxmon_run.sv
// Counts consecutive cycles of a condition and pulses once when the
// LIM-th consecutive cycle is sampled.
module usb_rxmon_run #(
  parameter int LIM = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic match,
  output logic hit
);
  localparam int CW = $clog2(LIM + 1);

  logic [CW-1:0] cnt;

  assign hit = match && (cnt == CW'(LIM - 1));

  always_ff @(posedge clk) begin
    if (rst || !match) begin
      cnt <= '0;
    end else if (cnt != CW'(LIM)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/usb_rxmon_pkt.sv
// Packet-in-flight flags, missing-EOP watchdog and receive interrupt.
module usb_rxmon_pkt
  import usb_rxmon_pkg::*;
#(
  parameter int WDT_CYC = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pid_vld,
  input  logic [3:0] pid,
  input  logic       eop,
  input  logic       irq_en,
  output logic [2:0] flags,
  output logic       wdt_exp,
  output logic       irq
);
  localparam int CW = $clog2(WDT_CYC + 1);

  logic          active;
  logic [CW-1:0] wcnt;
  logic [2:0]    cls;

  assign cls     = pid_class(pid);
  assign wdt_exp = active && !pid_vld && !eop && (wcnt == CW'(WDT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      active <= 1'b0;
      wcnt   <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= eop && irq_en && (flags[ST_DAT] || flags[ST_HSK]);
      if (pid_vld) begin
        flags  <= cls;
        active <= |cls;
        wcnt   <= '0;
      end else if (eop) begin
        flags  <= '0;
        active <= 1'b0;
        wcnt   <= '0;
      end else if (wdt_exp) begin
        active <= 1'b0;
      end else if (active) begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_rx_status_mon.sv
module usb_rx_status_mon
  import usb_rxmon_pkg::*;
#(
  parameter int CLK_HZ     = 48_000_000,
  parameter int BIT_HZ     = 12_000_000,
  parameter int RST_MIN_NS = 3000,
  parameter int RSM_BITS   = 8,
  parameter int WDT_BITS   = 64,
  parameter int ADDR_W     = 6,
  parameter int WR_LIMIT   = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        line_state,
  input  logic              pid_vld,
  input  logic [3:0]        pid,
  input  logic              eop,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              sw_clr,
  input  logic [7:3]        sw_clr_mask,
  input  logic              ctl_rst_mode,
  input  logic              ctl_irq_en,
  input  logic              ctl_wr_mask,
  output logic [7:0]        status,
  output logic              rx_irq,
  output logic              buf_wr_en
);
  localparam int CYC_PER_BIT = CLK_HZ / BIT_HZ;
  localparam int SE0_MIN_CYC = (CLK_HZ / 1000) * RST_MIN_NS / 1_000_000;
  localparam int RSM_CYC     = RSM_BITS * CYC_PER_BIT;
  localparam int WDT_CYC     = WDT_BITS * CYC_PER_BIT;

  line_t ls, ls_q;
  assign ls = line_t'(line_state);

  logic se0_entry, j_to_se0, se1_entry;
  logic se0_long, k_long;
  logic wdt_exp;
  logic [2:0] pkt_flags;
  logic [7:3] ev_q, ev_set, ev_clr;
  logic rst_set;

  assign se0_entry = (ls == LS_SE0) && (ls_q != LS_SE0);
  assign j_to_se0  = (ls == LS_SE0) && (ls_q == LS_J);
  assign se1_entry = (ls == LS_SE1) && (ls_q != LS_SE1);
  assign rst_set   = ctl_rst_mode ? j_to_se0 : se0_long;

  usb_rxmon_run #(.LIM(SE0_MIN_CYC)) i_se0_run (
    .clk(clk), .rst(rst), .match(ls == LS_SE0), .hit(se0_long)
  );

  usb_rxmon_run #(.LIM(RSM_CYC)) i_k_run (
    .clk(clk), .rst(rst), .match(ls == LS_K), .hit(k_long)
  );

  usb_rxmon_pkt #(.WDT_CYC(WDT_CYC)) i_pkt (
    .clk(clk), .rst(rst), .pid_vld(pid_vld), .pid(pid), .eop(eop),
    .irq_en(ctl_irq_en), .flags(pkt_flags), .wdt_exp(wdt_exp), .irq(rx_irq)
  );

  assign ev_set[ST_EOP] = eop;
  assign ev_set[ST_RST] = rst_set;
  assign ev_set[ST_SE0] = se0_entry;
  assign ev_set[ST_RSM] = k_long;
  assign ev_set[ST_WDT] = wdt_exp || se1_entry;
  assign ev_clr         = sw_clr ? sw_clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ls_q      <= LS_J;
      ev_q      <= '0;
      buf_wr_en <= 1'b0;
    end else begin
      ls_q      <= ls;
      ev_q      <= (ev_q & ~ev_clr) | ev_set;
      buf_wr_en <= wr_req && !(ctl_wr_mask && (int'(wr_addr) > WR_LIMIT));
    end
  end

  assign status = {ev_q, pkt_flags};
endmodule

// File: rtl/usb_rx_status_mon_chk.sv
module usb_rx_status_mon_chk #(
  parameter int ADDR_W   = 6,
  parameter int WR_LIMIT = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        line_state,
  input logic              pid_vld,
  input logic              eop,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              sw_clr,
  input logic              ctl_rst_mode,
  input logic              ctl_irq_en,
  input logic              ctl_wr_mask,
  input logic [7:0]        status,
  input logic              rx_irq,
  input logic              buf_wr_en
);
  AST_PKT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(status[2:0])); // R1

  AST_EOP_CLEARS_PKT: assert property (@(posedge clk) disable iff (rst)
    (eop && !pid_vld) |=> (status[2:0] == 3'b000)); // R2

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sw_clr |=> ((status[7:3] & $past(status[7:3])) == $past(status[7:3]))); // R3

  AST_MODE1_RESET: assert property (@(posedge clk) disable iff (rst)
    (ctl_rst_mode && line_state == 2'b00 && $past(line_state) == 2'b01) |=> status[4]); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !ctl_irq_en |=> !rx_irq); // R9

  AST_WR_MASK: assert property (@(posedge clk) disable iff (rst)
    (wr_req && ctl_wr_mask && int'(wr_addr) > WR_LIMIT) |=> !buf_wr_en); // R10

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (status == 8'h00 && !rx_irq && !buf_wr_en)); // R11
endmodule

bind usb_rx_status_mon usb_rx_status_mon_chk #(.ADDR_W(ADDR_W), .WR_LIMIT(WR_LIMIT)) i_chk (
  .clk(clk), .rst(rst), .line_state(line_state), .pid_vld(pid_vld), .eop(eop),
  .wr_req(wr_req), .wr_addr(wr_addr), .sw_clr(sw_clr), .ctl_rst_mode(ctl_rst_mode),
  .ctl_irq_en(ctl_irq_en), .ctl_wr_mask(ctl_wr_mask), .status(status),
  .rx_irq(rx_irq), .buf_wr_en(buf_wr_en)
);

// File: tb/test_usb_rx_status_mon.sv
`timescale 1ns/1ps
module test_usb_rx_status_mon;
  localparam int CLK_HZ = 48_000_000, BIT_HZ = 12_000_000;
  localparam int AW = 6;
  localparam int SE0_LIM = 3 * (CLK_HZ / 1_000_000);    // 3 us
  localparam int RSM_LIM = 8 * (CLK_HZ / BIT_HZ);        // 8 bit times
  localparam int WDT_LIM = 64 * (CLK_HZ / BIT_HZ);       // 64 bit times

  logic clk = 0, rst = 1;
  logic [1:0] line_state = 2'b01;
  logic pid_vld = 0, eop = 0, wr_req = 0, sw_clr = 0;
  logic [3:0] pid = 0;
  logic [AW-1:0] wr_addr = 0;
  logic [7:3] sw_clr_mask = 0;
  logic ctl_rst_mode = 0, ctl_irq_en = 0, ctl_wr_mask = 0;
  logic [7:0] status;
  logic rx_irq, buf_wr_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  usb_rx_status_mon #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ), .ADDR_W(AW)) i_usb_rx_status_mon (
    .clk(clk), .rst(rst), .line_state(line_state), .pid_vld(pid_vld), .pid(pid),
    .eop(eop), .wr_req(wr_req), .wr_addr(wr_addr), .sw_clr(sw_clr),
    .sw_clr_mask(sw_clr_mask), .ctl_rst_mode(ctl_rst_mode), .ctl_irq_en(ctl_irq_en),
    .ctl_wr_mask(ctl_wr_mask), .status(status), .rx_irq(rx_irq), .buf_wr_en(buf_wr_en)
  );

  function automatic logic [2:0] exp_class(input logic [3:0] p);
    case (p[1:0])
      2'b01:   return 3'b001;
      2'b11:   return 3'b010;
      2'b10:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic exp_wr(input logic req, input logic msk, input logic [AW-1:0] a);
    return req && !(msk && a > 6'h11);
  endfunction

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    sw_clr = 1; sw_clr_mask = 5'h1f; step(); sw_clr = 0; sw_clr_mask = 0;
  endtask

  task automatic send_pid(input logic [3:0] p);
    pid_vld = 1; pid = p; step(); pid_vld = 0;
  endtask

  task automatic send_eop();
    eop = 1; step(); eop = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    step(4);
    // R11 reset state
    chk("R11 status", status, 8'h00);
    chk("R11 rx_irq", rx_irq, 0);
    chk("R11 buf_wr_en", buf_wr_en, 0);
    rst = 0; step();

    // R1 random PIDs
    for (int i = 0; i < 40; i++) begin
      logic [3:0] p;
      p = 4'($urandom);
      send_pid(p);
      chk("R1 class", status[2:0], exp_class(p));
    end
    send_pid(4'b0011);
    sw_clr = 1; sw_clr_mask = 5'h1f; step(); sw_clr = 0; sw_clr_mask = 0;
    chk("R2 sw clear ignores pkt flags", status[2:0], 3'b010);
    send_eop();
    chk("R2 eop clears pkt", status[2:0], 3'b000);
    chk("R2 eop sets bit3", status[3], 1);

    // R3 set wins over clear; then clear alone
    eop = 1; sw_clr = 1; sw_clr_mask = 5'b00001; step(); eop = 0; sw_clr = 0;
    chk("R3 set wins", status[3], 1);
    sw_clr = 1; step(); sw_clr = 0; sw_clr_mask = 0;
    chk("R3 w1c", status[3], 0);
    step(3);
    chk("R3 stays clear", status[7:3], 5'h00);

    // R4 / R6 mode 1
    ctl_rst_mode = 1;
    line_state = 2'b00; step();
    chk("R4 se0 entry", status[5], 1);
    chk("R6 J to SE0 reset", status[4], 1);
    line_state = 2'b01; step(); clear_all();
    line_state = 2'b10; step(); line_state = 2'b00; step();
    chk("R6 K to SE0 no reset", status[4], 0);
    chk("R4 se0 entry from K", status[5], 1);
    line_state = 2'b01; step(); clear_all();

    // R5 mode 0 width filter
    ctl_rst_mode = 0;
    line_state = 2'b00; step(SE0_LIM - 1); line_state = 2'b01;
    chk("R5 short SE0 rejected", status[4], 0);
    step(); clear_all();
    line_state = 2'b00; step(SE0_LIM - 1);
    chk("R5 one below limit", status[4], 0);
    step();
    chk("R5 at limit", status[4], 1);
    line_state = 2'b01; step(); clear_all();

    // R7 resume
    line_state = 2'b10; step(RSM_LIM - 1); line_state = 2'b01;
    chk("R7 short K", status[6], 0);
    step();
    line_state = 2'b10; step(RSM_LIM);
    chk("R7 long K", status[6], 1);
    line_state = 2'b01; step(); clear_all();

    // R8 watchdog
    send_pid(4'b1001);
    step(WDT_LIM - 1);
    chk("R8 before timeout", status[7], 0);
    step();
    chk("R8 at timeout", status[7], 1);
    sw_clr = 1; sw_clr_mask = 5'b01111; step(); sw_clr = 0; sw_clr_mask = 0;
    chk("R8 other clears keep bit7", status[7], 1);
    send_eop(); clear_all();
    chk("R8 cleared by sw", status[7], 0);
    send_pid(4'b0010); step(WDT_LIM - 2); send_eop(); step(WDT_LIM);
    chk("R8 eop in time", status[7], 0);
    line_state = 2'b11; step(); line_state = 2'b01;
    chk("R8 SE1 noise", status[7], 1);
    step(); clear_all();

    // R9 interrupt
    ctl_irq_en = 1;
    send_pid(4'b1011); eop = 1; step(); eop = 0;
    chk("R9 data irq", rx_irq, 1);
    step();
    chk("R9 pulse one cycle", rx_irq, 0);
    send_pid(4'b1010); send_eop();
    chk("R9 handshake irq", rx_irq, 1);
    send_pid(4'b0101); send_eop();
    chk("R9 token no irq", rx_irq, 0);
    ctl_irq_en = 0;
    send_pid(4'b0011); send_eop();
    chk("R9 disabled", rx_irq, 0);

    // R10 write mask boundaries, then random
    ctl_wr_mask = 1; wr_req = 1; wr_addr = 6'h11; step();
    chk("R10 addr 0x11 masked mode", buf_wr_en, 1);
    wr_addr = 6'h12; step();
    chk("R10 addr 0x12 suppressed", buf_wr_en, 0);
    ctl_wr_mask = 0; step();
    chk("R10 unmasked 0x12", buf_wr_en, 1);
    for (int i = 0; i < 40; i++) begin
      logic r, m; logic [AW-1:0] a;
      r = 1'($urandom); m = 1'($urandom); a = AW'($urandom);
      wr_req = r; ctl_wr_mask = m; wr_addr = a; step();
      chk("R10 random", buf_wr_en, exp_wr(r, m, a));
    end
    wr_req = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule